// File: doc/BRIEF.md
# Link Echo Fault Locator

This block runs a reflectometry diagnostic on a serial Ethernet link. Software asks for a test with a single pulse, and the block accepts it only when the command and receive engines beside it are both idle. It then sends one test frame, one bit per clock, with the clock standing for one bit time. The frame is addressed from the station to itself.

While the frame goes out, a bit-time timer waits for an echo. The echo is either a rising collision indication or carrier sense falling. When the test ends, the block classifies the cable fault according to the configured transceiver type. A collision makes the block send a jam word and stop. In every case it then raises a one-cycle done pulse together with the measured echo time, a fault code and a not-applicable flag. These results are held until the next test ends.

Top module: `tdr_engine`

## Requirements
- R1: A start pulse is accepted only while the block is idle and both `cu_idle_i` and `ru_idle_i` are high. When the block is idle but either of those is low, `reject_o` pulses for one cycle and nothing is transmitted.
- R2: An accepted test drives `tx_en_o` high from the next cycle onward. `tx_d_o` carries, in this order:
  - 56 preamble bits alternating 1,0, starting with 1;
  - the byte 0xD5;
  - `stn_addr_i` as destination, bit 0 first;
  - `stn_addr_i` again as source, bit 0 first;
  - bytes of 0x7E.
  Every byte is sent least-significant bit first.
- R3: With no echo, the frame lasts exactly 2048 bit times and `tx_en_o` then falls.
- R4: If `cd_i` is high during a frame bit, that bit is still sent. Then 32 jam bits follow, after which `tx_en_o` falls. The jam bits are the complement of a CRC-32 register, sent from bit 31 down to bit 0. The register uses polynomial 0x04C11DB7 with initial value all ones, shifts MSB first, and is updated once per frame bit from the first destination bit through the collision bit.
- R5: The echo time counts bit times from the later of two points: the first frame bit (which counts as 0), or the bit after one in which carrier sense rose. On a timeout it is the count at the last frame bit.
- R6: The echo is `cd_i` high, or `crs_i` falling (high in the previous bit and low now). When both happen in the same bit, the collision takes priority.
- R7: With `eth_xcvr_i` high, the fault codes are:
  - 11: collision.
  - 10: carrier drop.
  - 01: timeout with `crs_i` never high during the frame.
  - 00: timeout otherwise.
  
  `na_o` is 0 in every case.
- R8: With `eth_xcvr_i` low, the fault codes are:
  - 11 with `na_o` 0: collision.
  - 00 with `na_o` 1: carrier drop.
  - 00 with `na_o` 0: timeout.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `tx_en_o` is low after the test. `echo_time_o`, `fault_o` and `na_o` change only in that cycle and hold until the next done.
- R10: A start pulse that arrives while a test is running is ignored. The test continues unchanged and no second test follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Test request pulse |
| cu_idle_i | input | 1 | Command engine idle |
| ru_idle_i | input | 1 | Receive engine idle |
| eth_xcvr_i | input | 1 | 1: transceiver echoes carrier; 0: it does not |
| stn_addr_i | input | 48 | Station address |
| crs_i | input | 1 | Carrier sense |
| cd_i | input | 1 | Collision detect |
| tx_en_o | output | 1 | Serial transmit enable |
| tx_d_o | output | 1 | Serial transmit data |
| reject_o | output | 1 | Start refused because a neighbour engine was busy |
| done_o | output | 1 | Test finished pulse |
| echo_time_o | output | 11 | Measured echo delay in bit times |
| fault_o | output | 2 | Fault code |
| na_o | output | 1 | Condition not applicable to this transceiver type |

## Verification
The hardest state to reach from the ports is a collision after the addresses are partly sent. In that case the jam content depends on every earlier bit, and the timer has already been cleared once by a carrier rise.

The bench drives carrier and collision on chosen bit numbers, counted from the first transmitted bit. It records every transmitted bit and recomputes the CRC-32 on its own side. It also places collisions inside the preamble, where the jam must be all zeros, and inserts a start pulse in the middle of a run.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_JAM} tdr_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_XCVR  = 2'b01,
    FLT_SHORT = 2'b10,
    FLT_OPEN  = 2'b11
  } tdr_fault_e;

  typedef enum logic [1:0] {EV_TIMEOUT, EV_CRS_DROP, EV_COLL} tdr_event_e;

  localparam int unsigned CRC_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [7:0] SFD_BYTE  = 8'hD5;
  localparam logic [7:0] FILL_BYTE = 8'h7E;
endpackage

// File: rtl/tdr_frame_gen.sv
module tdr_frame_gen #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned PRE_BITS = 56,
  parameter int unsigned IDX_W    = 11
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o,
  output logic              crc_en_o
);
  import tdr_pkg::*;

  localparam int unsigned AW        = $clog2(ADDR_W);
  localparam int unsigned DST_START = PRE_BITS + 8;
  localparam int unsigned SRC_START = DST_START + ADDR_W;
  localparam int unsigned DAT_START = SRC_START + ADDR_W;

  logic [IDX_W-1:0] off_sfd, off_dst, off_src, off_dat;

  always_comb begin
    off_sfd  = idx_i - IDX_W'(PRE_BITS);
    off_dst  = idx_i - IDX_W'(DST_START);
    off_src  = idx_i - IDX_W'(SRC_START);
    off_dat  = idx_i - IDX_W'(DAT_START);
    crc_en_o = (idx_i >= IDX_W'(DST_START));
    if (idx_i < IDX_W'(PRE_BITS))       bit_o = ~idx_i[0];
    else if (idx_i < IDX_W'(DST_START)) bit_o = SFD_BYTE[off_sfd[2:0]];
    else if (idx_i < IDX_W'(SRC_START)) bit_o = addr_i[off_dst[AW-1:0]];
    else if (idx_i < IDX_W'(DAT_START)) bit_o = addr_i[off_src[AW-1:0]];
    else                                bit_o = FILL_BYTE[off_dat[2:0]];
  end
endmodule

// File: rtl/tdr_crc32.sv
module tdr_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        din_i,
  output logic [31:0] crc_o
);
  import tdr_pkg::*;

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ din_i;
    crc_d = crc_q;
    if (clr_i)     crc_d = CRC_SEED;
    else if (en_i) crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tdr_classify.sv
module tdr_classify (
  input  logic                eth_i,
  input  tdr_pkg::tdr_event_e ev_i,
  input  logic                crs_seen_i,
  output tdr_pkg::tdr_fault_e fault_o,
  output logic                na_o
);
  import tdr_pkg::*;

  always_comb begin
    fault_o = FLT_NONE;
    na_o    = 1'b0;
    unique case (ev_i)
      EV_COLL:     fault_o = FLT_OPEN;
      EV_CRS_DROP: begin
        if (eth_i) fault_o = FLT_SHORT;
        else       na_o    = 1'b1;
      end
      default:     fault_o = (eth_i && !crs_seen_i) ? FLT_XCVR : FLT_NONE;
    endcase
  end
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned MAX_BITS = 2048,
  parameter int unsigned PRE_BITS = 56
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         cu_idle_i,
  input  logic                         ru_idle_i,
  input  logic                         eth_xcvr_i,
  input  logic [ADDR_W-1:0]            stn_addr_i,
  input  logic                         crs_i,
  input  logic                         cd_i,
  output logic                         tx_en_o,
  output logic                         tx_d_o,
  output logic                         reject_o,
  output logic                         done_o,
  output logic [$clog2(MAX_BITS)-1:0]  echo_time_o,
  output logic [1:0]                   fault_o,
  output logic                         na_o
);
  import tdr_pkg::*;

  localparam int unsigned IDX_W = $clog2(MAX_BITS);
  localparam int unsigned JAM_W = $clog2(CRC_W);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(MAX_BITS - 1);
  localparam logic [JAM_W-1:0] JAM_TOP  = JAM_W'(CRC_W - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  tdr_state_e       state_q, state_d;
  logic [IDX_W-1:0] bit_q, bit_d;
  logic [IDX_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] tcap_q, tcap_d;
  logic [JAM_W-1:0] jam_q, jam_d;
  logic             crs_q;
  logic             seen_q, seen_d;
  tdr_event_e       ev_q, ev_d;
  logic             done_q, done_d;
  logic             rej_q, rej_d;
  logic [IDX_W-1:0] time_q, time_d;
  tdr_fault_e       fault_q, fault_d;
  logic             na_q, na_d;

  logic             accept, crs_rise, crs_fall, finish;
  logic             gen_bit, gen_crc_en;
  logic [31:0]      crc;
  tdr_fault_e       cls_fault;
  logic             cls_na;

  tdr_frame_gen #(
    .ADDR_W  (ADDR_W),
    .PRE_BITS(PRE_BITS),
    .IDX_W   (IDX_W)
  ) u_gen (
    .idx_i   (bit_q),
    .addr_i  (stn_addr_i),
    .bit_o   (gen_bit),
    .crc_en_o(gen_crc_en)
  );

  tdr_crc32 u_crc (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr_i(accept),
    .en_i ((state_q == ST_SEND) && gen_crc_en),
    .din_i(gen_bit),
    .crc_o(crc)
  );

  tdr_classify u_cls (
    .eth_i     (eth_xcvr_i),
    .ev_i      (ev_d),
    .crs_seen_i(seen_d),
    .fault_o   (cls_fault),
    .na_o      (cls_na)
  );

  assign crs_rise = crs_i & ~crs_q;
  assign crs_fall = crs_q & ~crs_i;
  assign accept   = (state_q == ST_IDLE) && start_i && cu_idle_i && ru_idle_i;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    tmr_d   = tmr_q;
    tcap_d  = tcap_q;
    jam_d   = jam_q;
    seen_d  = seen_q;
    ev_d    = ev_q;
    finish  = 1'b0;
    rej_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !(cu_idle_i && ru_idle_i)) rej_d = 1'b1;
        if (accept) begin
          state_d = ST_SEND;
          bit_d   = '0;
          tmr_d   = '0;
          seen_d  = 1'b0;
        end
      end
      ST_SEND: begin
        seen_d = seen_q | crs_i;
        if (cd_i) begin
          ev_d    = EV_COLL;
          tcap_d  = tmr_q;
          jam_d   = '0;
          state_d = ST_JAM;
        end else if (crs_fall) begin
          ev_d    = EV_CRS_DROP;
          finish  = 1'b1;
        end else if (bit_q == LAST_BIT) begin
          ev_d    = EV_TIMEOUT;
          finish  = 1'b1;
        end else begin
          bit_d = bit_q + IDX_W'(1);
          tmr_d = crs_rise ? '0 : tmr_q + IDX_W'(1);
        end
      end
      ST_JAM: begin
        jam_d = jam_q + JAM_W'(1);
        if (jam_q == JAM_TOP) finish = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  // result capture, loaded only on the finishing bit
  always_comb begin
    done_d  = finish;
    time_d  = time_q;
    fault_d = fault_q;
    na_d    = na_q;
    if (finish) begin
      time_d  = (state_q == ST_JAM) ? tcap_q : tmr_q;
      fault_d = cls_fault;
      na_d    = cls_na;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      tmr_q   <= '0;
      tcap_q  <= '0;
      jam_q   <= '0;
      crs_q   <= 1'b0;
      seen_q  <= 1'b0;
      ev_q    <= EV_TIMEOUT;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      time_q  <= '0;
      fault_q <= FLT_NONE;
      na_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      tmr_q   <= tmr_d;
      tcap_q  <= tcap_d;
      jam_q   <= jam_d;
      crs_q   <= crs_i;
      seen_q  <= seen_d;
      ev_q    <= ev_d;
      done_q  <= done_d;
      rej_q   <= rej_d;
      time_q  <= time_d;
      fault_q <= fault_d;
      na_q    <= na_d;
    end
  end

  always_comb begin
    tx_en_o = (state_q != ST_IDLE);
    tx_d_o  = 1'b0;
    if (state_q == ST_SEND)     tx_d_o = gen_bit;
    else if (state_q == ST_JAM) tx_d_o = ~crc[JAM_TOP - jam_q];
  end

  assign reject_o    = rej_q;
  assign done_o      = done_q;
  assign echo_time_o = time_q;
  assign fault_o     = fault_q;
  assign na_o        = na_q;
endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       cu_idle_i,
  input logic       ru_idle_i,
  input logic       tx_en_o,
  input logic       reject_o,
  input logic       done_o,
  input logic [1:0] fault_o,
  input logic       na_o
);
  AST_TX_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(start_i && cu_idle_i && ru_idle_i)); // R1
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> $past(start_i && !(cu_idle_i && ru_idle_i))); // R1
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !tx_en_o); // R1
  AST_NA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    na_o |-> (fault_o == 2'b00)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tx_en_o); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(fault_o) && $stable(na_o))); // R9
endmodule

bind tdr_engine tdr_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .cu_idle_i(cu_idle_i),
  .ru_idle_i(ru_idle_i),
  .tx_en_o  (tx_en_o),
  .reject_o (reject_o),
  .done_o   (done_o),
  .fault_o  (fault_o),
  .na_o     (na_o)
);

// File: tb/sim_tdr_engine.sv
module sim_tdr_engine;
  localparam int CLK_P = 10;

  logic        clk, rst_n, start_i, cu_idle_i, ru_idle_i, eth_xcvr_i;
  logic [47:0] stn_addr_i;
  logic        crs_i, cd_i;
  logic        tx_en_o, tx_d_o, reject_o, done_o, na_o;
  logic [10:0] echo_time_o;
  logic [1:0]  fault_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  tdr_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cu_idle_i(cu_idle_i),
    .ru_idle_i(ru_idle_i), .eth_xcvr_i(eth_xcvr_i), .stn_addr_i(stn_addr_i),
    .crs_i(crs_i), .cd_i(cd_i), .tx_en_o(tx_en_o), .tx_d_o(tx_d_o),
    .reject_o(reject_o), .done_o(done_o), .echo_time_o(echo_time_o),
    .fault_o(fault_o), .na_o(na_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(input int i, input logic [47:0] a);
    logic [7:0] sfd, fill;
    sfd  = 8'hD5;
    fill = 8'h7E;
    if (i < 56)  return (i % 2 == 0);
    if (i < 64)  return sfd[i-56];
    if (i < 112) return a[i-64];
    if (i < 160) return a[i-112];
    return fill[(i-160) % 8];
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[31] ^ b;
    return {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
  endfunction

  // one full diagnostic run; bit numbers count from the first transmitted bit
  task automatic run_tdr(input string name, input bit eth, input int rise_at,
                         input int drop_at, input int cd_at, input int busy_at,
                         input int exp_len, input int exp_fault, input bit exp_na,
                         input int exp_time);
    logic [31:0] crc;
    int i, nfr, bad_bits, first_bad;
    logic expb;
    @(negedge clk);
    eth_xcvr_i = eth; cu_idle_i = 1; ru_idle_i = 1; start_i = 1; crs_i = 0; cd_i = 0;
    @(negedge clk);
    start_i = 0;
    nfr = (cd_at >= 0) ? cd_at + 1 : exp_len;
    crc = 32'hFFFFFFFF;
    i = 0; bad_bits = 0; first_bad = -1;
    while (tx_en_o && i < 2200) begin
      if (i < nfr) begin
        expb = frame_bit(i, stn_addr_i);
        if (i >= 64) crc = crc_step(crc, expb);
      end else begin
        expb = ~crc[31-(i-nfr)];
      end
      if (tx_d_o !== expb) begin
        bad_bits++;
        if (first_bad < 0) first_bad = i;
      end
      crs_i   = (rise_at >= 0 && i >= rise_at && (drop_at < 0 || i < drop_at));
      cd_i    = (cd_at >= 0 && i >= cd_at);
      start_i = (i == busy_at);
      @(negedge clk);
      i++;
    end
    // R2 R4: serial content of frame and jam
    chk(bad_bits == 0, {name, " R2/R4 bit stream, first bad bit index"}, first_bad, -1);
    // R3 R4 R6: length of the transmission
    chk(i == exp_len, {name, " R3 frame length"}, i, exp_len);
    chk(done_o == 1, {name, " R9 done with tx off"}, done_o, 1);
    chk(echo_time_o == exp_time, {name, " R5 echo time"}, echo_time_o, exp_time);
    chk(fault_o == exp_fault, {name, " R7/R8 fault code"}, fault_o, exp_fault);
    chk(na_o == exp_na, {name, " R8 na flag"}, na_o, exp_na);
    crs_i = 0; cd_i = 0; start_i = 0;
    @(negedge clk);
    chk(done_o == 0, {name, " R9 done single cycle"}, done_o, 0);
    chk(echo_time_o == exp_time && fault_o == exp_fault, {name, " R9 results held"},
        echo_time_o, exp_time);
    chk(tx_en_o == 0, {name, " R10 no follow-on run"}, tx_en_o, 0);
  endtask

  task automatic t_reset;
    chk(tx_en_o == 0, "reset R2 tx_en", tx_en_o, 0);
    chk(done_o == 0, "reset R9 done", done_o, 0);
    chk(reject_o == 0, "reset R1 reject", reject_o, 0);
    chk(fault_o == 0 && na_o == 0 && echo_time_o == 0, "reset R9 results", fault_o, 0);
  endtask

  task automatic t_reject(input bit cu, input bit ru);
    @(negedge clk);
    cu_idle_i = cu; ru_idle_i = ru; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(reject_o == 1, "R1 reject pulse", reject_o, 1);
    chk(tx_en_o == 0, "R1 no tx on reject", tx_en_o, 0);
    @(negedge clk);
    chk(reject_o == 0 && tx_en_o == 0, "R1 reject clears, still idle", reject_o, 0);
    cu_idle_i = 1; ru_idle_i = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; cu_idle_i = 1; ru_idle_i = 1; eth_xcvr_i = 1;
    stn_addr_i = 48'h0A1B_2C3D_4E5F; crs_i = 0; cd_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reject(0, 1);
    t_reject(1, 0);
    // R7: carrier follows, no echo -> no problem
    run_tdr("eth_quiet",   1, 3, -1, -1, -1, 2048, 0, 0, 2043);
    // R7: carrier never seen -> transceiver cable
    run_tdr("eth_nocrs",   1, -1, -1, -1, -1, 2048, 1, 0, 2047);
    // R6 R7: carrier drop -> short
    run_tdr("eth_drop",    1, 2, 300, -1, -1, 301, 2, 0, 297);
    // R4 R7: collision after addresses -> open, jam appended
    run_tdr("eth_coll",    1, 2, -1, 200, -1, 233, 3, 0, 197);
    // R4: collision in preamble, jam all zeros
    run_tdr("eth_coll_pre", 1, -1, -1, 10, -1, 43, 3, 0, 10);
    // R6: collision and carrier drop together, collision wins
    run_tdr("eth_both",    1, 4, 90, 90, -1, 123, 3, 0, 85);
    stn_addr_i = 48'hF0E1_D2C3_B4A5;
    // R8 R10: non-ethernet collision with a start mid-run
    run_tdr("ne_coll",     0, -1, -1, 150, 20, 183, 3, 0, 150);
    // R8: carrier drop not applicable
    run_tdr("ne_drop",     0, 5, 40, -1, -1, 41, 0, 1, 34);
    // R8: no echo
    run_tdr("ne_quiet",    0, -1, -1, -1, -1, 2048, 0, 0, 2047);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule